// File: doc/BRIEF.md
# Multi-Load Energy Bucket Controller

This block keeps a saturating energy accumulator (the bucket) and drives a bank of load enable lines against two thresholds. Once per mains cycle, marked by a one-clock pulse on `cycle_i`, the signed energy measured over that cycle is added to the bucket. A full bucket asks for one more load to be turned on. A bucket that has drained asks for one load to be turned off. Each decision reaches the enable lines at the following cycle pulse, which models the half-cycle wait for the next zero crossing.

The load that switched last is the active load. For `HOLD` cycle pulses after any switch, no further switch in the same direction is allowed. During that window the threshold that caused the switch follows the bucket outward, so it records the peak or trough that the bucket reaches while the switch is taking effect. After the window, the next load is brought in only if the bucket moves past that recorded level. The active load can still be switched back during the window. Loads form a thermometer: they are enabled in rising index order and released in falling index order.

Top module: `bucket_load_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first decision is applied, all of `load_en_o` is 0. The bucket resets to 0 and the thresholds reset to their nominal values `THR_HI` and `THR_LO`.
- R2: On each `cycle_i` pulse the bucket becomes bucket + `energy_i`, where `energy_i` is a two's-complement value. The result is clamped to the range 0 to `CAP`.
- R3: On a pulse, if the updated bucket is strictly above the upper threshold and fewer than `N_LOADS` loads are on, the lowest-index load that is off is chosen to turn on. If the updated bucket is strictly below the lower threshold and at least one load is on, the highest-index load that is on is chosen to turn off. At most one load changes per pulse.
- R4: A decision made at one pulse appears on `load_en_o` at the next pulse. `load_en_o` changes only in the clock after a pulse.
- R5: After any switch, a hold window lasts for the next `HOLD` pulses. During the window, a switch in the same direction as the last switch is not made.
- R6: A switch-on sets the upper threshold to the updated bucket value. While a hold window that follows a switch-on is open, each bucket value above that threshold raises the threshold to the bucket value. A switch-off does the same for the lower threshold, moving it downward. After the window, the next load in that direction needs the bucket to go strictly beyond the tracked level.
- R7: While a hold window is open, a switch in the opposite direction is allowed. That switch releases the active load, and it starts a new hold window in the new direction.
- R8: When there is no switch and no tracking in that direction, a threshold returns to nominal once the bucket is back on the inner side of the nominal value (upper: bucket <= `THR_HI`; lower: bucket >= `THR_LO`). A switch in one direction resets the threshold for the other direction to nominal.
- R9: `energy_i` has no effect in clocks where `cycle_i` is low.
- R10: `load_en_o` is always a thermometer code: bits 0 to k-1 set, all others clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | 1 | One-clock pulse at the start of each mains cycle |
| energy_i | input | EW | Signed energy measured over the last cycle |
| load_en_o | output | N_LOADS | Load enable lines, bit 0 switched first |

## Verification
The assertions assume that `cycle_i` pulses are separated by idle clocks and that `energy_i` stays within its signed range. They also assume parameters where `THR_LO` is below `THR_HI` and `THR_HI` is below `CAP`, so the two threshold bands never overlap. The stimulus sends one-clock pulses with three idle clocks between them and puts large non-zero values on `energy_i` during the idle clocks, which checks that input is ignored. A directed sequence drives the bucket against both clamp limits, through hold windows with threshold tracking, through a reversal of the active load, and through the return of a threshold to nominal. A random phase then keeps the bucket moving around both thresholds.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/blc_bucket.sv
module blc_bucket #(
  parameter int BW  = 10,
  parameter int EW  = 11,
  parameter int CAP = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cycle_i,
  input  logic signed [EW-1:0] energy_i,
  output logic [BW-1:0]        level_nxt_o,
  output logic [BW-1:0]        level_q_o
);
  localparam int SW = BW + 2;
  localparam logic signed [SW-1:0] CAP_S = SW'(CAP);
  localparam logic [BW-1:0]        CAP_V = BW'(CAP);

  logic signed [SW-1:0] ext_e, sum;
  logic [BW-1:0] level_q;

  always_comb begin
    ext_e = SW'(energy_i);
    sum   = $signed({2'b00, level_q}) + ext_e;
    if (sum < 0)          level_nxt_o = '0;
    else if (sum > CAP_S) level_nxt_o = CAP_V;
    else                  level_nxt_o = sum[BW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      level_q <= '0;
    else if (cycle_i) level_q <= level_nxt_o;
  end

  assign level_q_o = level_q;
endmodule

// File: rtl/blc_thresh.sv
module blc_thresh #(
  parameter int BW    = 10,
  parameter int NOM   = 600,
  parameter bit UPPER = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cycle_i,
  input  logic [BW-1:0] level_i,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic          track_i,
  output logic [BW-1:0] thr_o
);
  localparam logic [BW-1:0] NOM_V = BW'(NOM);

  logic [BW-1:0] thr_q;

  // outward side of a threshold
  function automatic logic beyond(input logic [BW-1:0] a, input logic [BW-1:0] b);
    return UPPER ? (a > b) : (a < b);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= NOM_V;
    end else if (cycle_i) begin
      if (set_i)                      thr_q <= level_i;
      else if (clr_i)                 thr_q <= NOM_V;
      else if (track_i) begin
        if (beyond(level_i, thr_q))   thr_q <= level_i;
      end else if (!beyond(level_i, NOM_V)) thr_q <= NOM_V;
    end
  end

  assign thr_o = thr_q;
endmodule

// File: rtl/blc_seq.sv
module blc_seq
  import blc_pkg::*;
#(
  parameter int N_LOADS = 4,
  parameter int HOLD    = 3,
  parameter int BW      = 10,
  localparam int CW     = $clog2(N_LOADS + 1),
  localparam int HW     = $clog2(HOLD + 1),
  localparam int AW     = (N_LOADS > 1) ? $clog2(N_LOADS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cycle_i,
  input  logic [BW-1:0]      level_i,
  input  logic [BW-1:0]      hi_i,
  input  logic [BW-1:0]      lo_i,
  output logic               sw_up_o,
  output logic               sw_dn_o,
  output logic               hold_o,
  output dir_e               dir_o,
  output logic [CW-1:0]      cnt_o,
  output logic [AW-1:0]      active_o,
  output logic [N_LOADS-1:0] load_en_o
);
  logic [CW-1:0]      cnt_q;
  logic [HW-1:0]      hold_q;
  dir_e               dir_q;
  logic [AW-1:0]      active_q;
  logic [N_LOADS-1:0] mask, en_q;

  assign hold_o  = (hold_q != '0);
  assign sw_up_o = cycle_i && (cnt_q < CW'(N_LOADS)) && (level_i > hi_i)
                   && !(hold_o && dir_q == DIR_UP);
  assign sw_dn_o = cycle_i && (cnt_q != '0) && (level_i < lo_i)
                   && !(hold_o && dir_q == DIR_DN);

  for (genvar i = 0; i < N_LOADS; i++) begin : g_mask
    assign mask[i] = (cnt_q > CW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      hold_q   <= '0;
      dir_q    <= DIR_UP;
      active_q <= '0;
      en_q     <= '0;
    end else if (cycle_i) begin
      en_q <= mask;  // last pulse's decision takes effect now
      if (sw_up_o) begin
        active_q <= AW'(cnt_q);
        cnt_q    <= cnt_q + CW'(1);
        hold_q   <= HW'(HOLD);
        dir_q    <= DIR_UP;
      end else if (sw_dn_o) begin
        active_q <= AW'(cnt_q - CW'(1));
        cnt_q    <= cnt_q - CW'(1);
        hold_q   <= HW'(HOLD);
        dir_q    <= DIR_DN;
      end else if (hold_o) begin
        hold_q <= hold_q - HW'(1);
      end
    end
  end

  assign dir_o     = dir_q;
  assign cnt_o     = cnt_q;
  assign active_o  = active_q;
  assign load_en_o = en_q;
endmodule

// File: rtl/bucket_load_ctrl.sv
module bucket_load_ctrl
  import blc_pkg::*;
#(
  parameter int N_LOADS = 4,
  parameter int BW      = 10,
  parameter int EW      = 11,
  parameter int CAP     = 1000,
  parameter int THR_HI  = 600,
  parameter int THR_LO  = 400,
  parameter int HOLD    = 3,
  localparam int CW     = $clog2(N_LOADS + 1),
  localparam int AW     = (N_LOADS > 1) ? $clog2(N_LOADS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cycle_i,
  input  logic signed [EW-1:0] energy_i,
  output logic [N_LOADS-1:0]   load_en_o
);
  logic [BW-1:0] level_nxt, level_q, thr_hi, thr_lo;
  logic          sw_up, sw_dn, in_hold;
  dir_e          dir;
  logic [CW-1:0] cnt;
  logic [AW-1:0] active;

  blc_bucket #(.BW(BW), .EW(EW), .CAP(CAP)) u_bucket (
    .clk_i, .rst_ni, .cycle_i, .energy_i,
    .level_nxt_o(level_nxt), .level_q_o(level_q)
  );

  blc_thresh #(.BW(BW), .NOM(THR_HI), .UPPER(1'b1)) u_thr_hi (
    .clk_i, .rst_ni, .cycle_i, .level_i(level_nxt),
    .set_i(sw_up), .clr_i(sw_dn), .track_i(in_hold && dir == DIR_UP),
    .thr_o(thr_hi)
  );

  blc_thresh #(.BW(BW), .NOM(THR_LO), .UPPER(1'b0)) u_thr_lo (
    .clk_i, .rst_ni, .cycle_i, .level_i(level_nxt),
    .set_i(sw_dn), .clr_i(sw_up), .track_i(in_hold && dir == DIR_DN),
    .thr_o(thr_lo)
  );

  blc_seq #(.N_LOADS(N_LOADS), .HOLD(HOLD), .BW(BW)) u_seq (
    .clk_i, .rst_ni, .cycle_i, .level_i(level_nxt),
    .hi_i(thr_hi), .lo_i(thr_lo),
    .sw_up_o(sw_up), .sw_dn_o(sw_dn), .hold_o(in_hold), .dir_o(dir),
    .cnt_o(cnt), .active_o(active), .load_en_o(load_en_o)
  );
endmodule

// File: rtl/bucket_load_ctrl_chk.sv
module bucket_load_ctrl_chk
  import blc_pkg::*;
#(
  parameter int N_LOADS = 4,
  parameter int BW      = 10,
  parameter int CAP     = 1000,
  parameter int THR_HI  = 600,
  parameter int THR_LO  = 400,
  localparam int CW     = $clog2(N_LOADS + 1),
  localparam int AW     = (N_LOADS > 1) ? $clog2(N_LOADS) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cycle_i,
  input logic [N_LOADS-1:0] load_en_i,
  input logic [BW-1:0]      level_i,
  input logic [BW-1:0]      hi_i,
  input logic [BW-1:0]      lo_i,
  input logic               hold_i,
  input dir_e               dir_i,
  input logic [CW-1:0]      cnt_i,
  input logic [AW-1:0]      active_i
);
  // R10
  thermo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((load_en_i & (load_en_i + 1'b1)) == '0));

  // R4
  stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_i |=> $stable(load_en_i));

  // R2
  cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= BW'(CAP));

  // R5
  hold_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i && hold_i && dir_i == DIR_UP) |=> cnt_i <= $past(cnt_i));

  // R5
  hold_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i && hold_i && dir_i == DIR_DN) |=> cnt_i >= $past(cnt_i));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_i |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + 1'b1)
               || ($past(cnt_i) == cnt_i + 1'b1));

  // R6
  band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_i >= BW'(THR_HI)) && (lo_i <= BW'(THR_LO)));

  // R7
  reverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i && hold_i && dir_i == DIR_UP)
      |=> (cnt_i >= $past(cnt_i)) || (active_i == $past(active_i)));
endmodule

bind bucket_load_ctrl bucket_load_ctrl_chk #(
  .N_LOADS(N_LOADS), .BW(BW), .CAP(CAP), .THR_HI(THR_HI), .THR_LO(THR_LO)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cycle_i(cycle_i), .load_en_i(load_en_o),
  .level_i(level_q), .hi_i(thr_hi), .lo_i(thr_lo), .hold_i(in_hold),
  .dir_i(dir), .cnt_i(cnt), .active_i(active)
);

// File: tb/sim_bucket_load_ctrl.sv
`timescale 1ns/1ps
module sim_bucket_load_ctrl;
  localparam int N    = 4;
  localparam int EW   = 11;
  localparam int CAP  = 1000;
  localparam int HI   = 600;
  localparam int LO   = 400;
  localparam int HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0, cycle = 1'b0;
  logic signed [EW-1:0] energy = '0;
  logic [N-1:0] load_en;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bucket_load_ctrl #(.N_LOADS(N), .EW(EW), .CAP(CAP), .THR_HI(HI),
                     .THR_LO(LO), .HOLD(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cycle), .energy_i(energy),
    .load_en_o(load_en)
  );

  // behavioural reference
  int mb, mhi, mlo, mn, mh, mout;
  bit mup;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb = 0; mhi = HI; mlo = LO; mn = 0; mh = 0; mup = 1; mout = 0;
    end else if (cycle) begin
      int t, nhi, nlo;
      bit up, dn;
      mout = mn;
      t = mb + int'(energy);
      if (t < 0) t = 0;
      if (t > CAP) t = CAP;
      mb = t;
      up = (mn < N) && (mb > mhi) && !(mh > 0 && mup);
      dn = (mn > 0) && (mb < mlo) && !(mh > 0 && !mup);
      nhi = mhi; nlo = mlo;
      if (up) begin nhi = mb; nlo = LO; end
      else if (dn) begin nhi = HI; nlo = mb; end
      else begin
        if (mh > 0 && mup) begin if (mb > mhi) nhi = mb; end
        else if (mb <= HI) nhi = HI;
        if (mh > 0 && !mup) begin if (mb < mlo) nlo = mb; end
        else if (mb >= LO) nlo = LO;
      end
      mhi = nhi; mlo = nlo;
      if (up) begin mn++; mh = HOLD; mup = 1; end
      else if (dn) begin mn--; mh = HOLD; mup = 0; end
      else if (mh > 0) mh--;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] exp_v;
      exp_v = N'((1 << mout) - 1);
      n_cmp++;
      if (load_en !== exp_v) begin
        n_bad++;
        $display("FAIL R3 model t=%0t got %b exp %b", $time, load_en, exp_v);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input logic [N-1:0] exp_v, input string tag);
    n_cmp++;
    if (load_en !== exp_v) begin
      n_bad++;
      $display("FAIL %s got %b exp %b", tag, load_en, exp_v);
    end
  endtask

  // one-clock pulse, then idle clocks with junk on energy (R9)
  task automatic pulse(input int e);
    @(negedge clk);
    energy = EW'(e);
    cycle  = 1'b1;
    @(negedge clk);
    cycle  = 1'b0;
    energy = EW'(900);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    energy = EW'(900);
    repeat (3) @(negedge clk);
    check('0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check('0, "R1 after reset");

    pulse(700);  check(4'b0000, "R4 lag");
    pulse(50);   check(4'b0001, "R4 applied");
    pulse(50);   check(4'b0001, "R5 hold");
    pulse(0);    check(4'b0001, "R5 hold end");
    pulse(0);    check(4'b0001, "R6 tracked peak");
    pulse(10);   check(4'b0001, "R6 pending");
    pulse(0);    check(4'b0011, "R3 ascending");
    pulse(-500); check(4'b0011, "R7 pending");
    pulse(0);    check(4'b0001, "R7 reversal");
    pulse(-10);  check(4'b0001, "R6 trough");
    pulse(0);    check(4'b0001, "R6 trough hold");
    pulse(-5);   check(4'b0001, "R6 beyond trough");
    pulse(0);    check(4'b0000, "R3 descending");
    pulse(0);
    pulse(0);
    pulse(-512); check(4'b0000, "R2 floor");
    pulse(-512);
    pulse(500);
    pulse(101);  check(4'b0000, "R2 floor pending");
    pulse(0);    check(4'b0001, "R2 floor clamp");
    pulse(0);
    pulse(0);
    pulse(511);  check(4'b0001, "R2 cap pending");
    pulse(0);    check(4'b0011, "R2 cap on");
    pulse(-601);
    pulse(0);    check(4'b0001, "R2 cap clamp");
    pulse(0);
    pulse(0);
    pulse(1);
    pulse(-1);   check(4'b0001, "R8 pending");
    pulse(0);    check(4'b0000, "R8 relax");
    energy = EW'(1000);
    repeat (20) @(negedge clk);
    pulse(0);    check(4'b0000, "R9 ignore");
    pulse(0);    check(4'b0000, "R9 ignore late");

    for (int k = 0; k < 400; k++) begin
      pulse(int'($urandom_range(0, 300)) - 150);
    end
    check(N'((1 << mout) - 1), "R10 final state");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule